// File: doc/BRIEF.md
# Streamed Instruction Window Controller

This block lets a processor core execute straight-line code that lives in a large shared memory, while still fetching every instruction from a small group of local registers. The local group is an eight-word window. Each word is 32 bits, and the whole window is loaded as one 256-bit line. A start command gives the controller an 18-bit shared-memory pointer. The controller reads the first line during a shared-memory access slot and holds the core stalled until that line is in the window. After that it keeps requesting the following lines on its own, one slot at a time, and stages each one until the core's program counter wraps.

While streaming is on, only the low three bits of the program counter advance. Stepping past the last word brings the counter back to the first word of the window, and at that moment the next staged line replaces the window contents. A branch that lands inside the window is an ordinary local jump. A branch that lands outside it ends streaming, and the core then carries on from local registers as usual. The window base is an input, so the window can sit anywhere in the local register space on an eight-word boundary.

Top module: `hubwin_ctrl`

## Requirements
- R1: Each line the controller accepts is written to the window in one cycle. During that cycle `win_we` is high, `win_wdata` equals the returned 256-bit line with word i in bits [32i+31:32i], and `win_waddr` equals `win_base` with its low three bits cleared.
- R2: While streaming and not stalled, each `step` adds one to bits [2:0] of `pc` and leaves bits [8:3] unchanged. A step taken at word 7 returns `pc` to word 0 of the same window.
- R3: The first read after a start uses `start_ptr`. Every later read uses the previous read address plus 32, taken modulo 2^18.
- R4: `mem_req` is asserted only in access-slot cycles. The first slot is the first cycle after reset is released, and later slots follow every SLOT_PERIOD cycles.
- R5: A start sets `pc` to the aligned window base, turns streaming on and raises `stall`. `stall` stays high until the first line has been written. `stall` is low whenever streaming is off, including after reset.
- R6: After a line enters the window, the controller issues the next read at the following slot without any command. It has at most one read outstanding or staged.
- R7: A branch whose target has the same bits [8:3] as the window base sets `pc` to the target. Streaming stays on and no window write occurs.
- R8: A branch whose target is outside the window turns streaming off and sets `pc` to the target. Later steps then increment all bits of `pc`. A line still in flight is discarded, and no further reads are issued.
- R9: If a step wraps `pc` before the next line has arrived, `pc` goes to word 0 and `stall` rises. Steps are ignored while `stall` is high. The arriving line is written to the window and `stall` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start-streaming command pulse |
| start_ptr | input | 18 | Shared-memory byte address of the first line |
| win_base | input | 9 | Local register address of the window (low 3 bits ignored) |
| step | input | 1 | Core advances one instruction |
| branch | input | 1 | Core takes a branch this cycle |
| branch_tgt | input | 9 | Local target address of the branch |
| pc | output | 9 | Program counter for the core |
| stream_on | output | 1 | Streaming mode active |
| stall | output | 1 | Window not executable; core must wait |
| mem_req | output | 1 | Line read request in the current slot |
| mem_addr | output | 18 | Byte address of the requested line |
| fill_valid | input | 1 | Returned line valid |
| fill_data | input | 256 | Returned line |
| win_we | output | 1 | Window write strobe |
| win_waddr | output | 9 | Window base address for the write |
| win_wdata | output | 256 | Line written into the window |

## Verification
The bench builds the controller with a slot period of 4 and keeps the default 18-bit pointer and 9-bit program counter. With the short slot period, the bench can set the memory latency either below or above the time the core needs to run through a window. This makes both the staged-line wrap and the stalled wrap reachable within a few dozen cycles. With the full 18-bit pointer, a start near the top of shared memory shows the address rolling over to zero. A branch out issued one cycle after a request shows that the in-flight line is discarded.

// File: rtl/hubwin_pkg.sv
package hubwin_pkg;

  // Advance a byte pointer by one line, wrapping at the pointer width.
  function automatic logic [31:0] ptr_next(input logic [31:0] p,
                                           input int unsigned line_bytes,
                                           input int unsigned w);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (p + line_bytes) & m;
  endfunction

  // Two local addresses share a window when all bits above the index agree.
  function automatic logic same_window(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned lo);
    return (a >> lo) == (b >> lo);
  endfunction

endpackage

// File: rtl/hubwin_slot.sv
module hubwin_slot #(
  parameter int SLOT_PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (SLOT_PERIOD > 1) ? $clog2(SLOT_PERIOD) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == CW'(SLOT_PERIOD - 1)) cnt <= '0;
    else cnt <= cnt + CW'(1);
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/hubwin_fetch.sv
module hubwin_fetch
  import hubwin_pkg::*;
#(
  parameter int PTR_W      = 18,
  parameter int LINE_W     = 256,
  parameter int LINE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic              slot_tick,
  input  logic              leave,
  input  logic              wrap,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data,
  output logic              stream_on,
  output logic              win_valid,
  output logic              mem_req,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              win_load,
  output logic [LINE_W-1:0] win_wdata
);
  logic              stream_q, valid_q, pend, inflight, drop, nxt_ok;
  logic [PTR_W-1:0]  ptr;
  logic [LINE_W-1:0] nxt_buf;
  logic              issue, fill_acc, good, take_nxt, load;

  assign issue    = stream_q & pend & ~inflight & slot_tick & ~start & ~leave;
  assign fill_acc = fill_valid & inflight;
  assign good     = fill_acc & ~drop & stream_q & ~start & ~leave;
  assign take_nxt = wrap & nxt_ok;
  assign load     = (good & ~valid_q) | (wrap & (nxt_ok | good));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stream_q <= 1'b0;
      valid_q  <= 1'b0;
      pend     <= 1'b0;
      inflight <= 1'b0;
      drop     <= 1'b0;
      nxt_ok   <= 1'b0;
      ptr      <= '0;
      nxt_buf  <= '0;
    end else begin
      if (issue) ptr <= PTR_W'(ptr_next(32'(ptr), LINE_BYTES, PTR_W));
      if (issue) inflight <= 1'b1;
      else if (fill_acc) inflight <= 1'b0;

      if (start) begin
        ptr      <= start_ptr;
        stream_q <= 1'b1;
        valid_q  <= 1'b0;
        pend     <= 1'b1;
        nxt_ok   <= 1'b0;
        drop     <= inflight & ~fill_acc;
      end else if (leave) begin
        stream_q <= 1'b0;
        valid_q  <= 1'b0;
        pend     <= 1'b0;
        nxt_ok   <= 1'b0;
        drop     <= inflight & ~fill_acc;
      end else begin
        if (fill_acc) drop <= 1'b0;
        if (load) begin
          valid_q <= 1'b1;
          pend    <= 1'b1;
        end else begin
          if (wrap)  valid_q <= 1'b0;
          if (issue) pend    <= 1'b0;
        end
        if (take_nxt) nxt_ok <= 1'b0;
        else if (good & valid_q & ~wrap) begin
          nxt_buf <= fill_data;
          nxt_ok  <= 1'b1;
        end
      end
    end
  end

  assign stream_on = stream_q;
  assign win_valid = valid_q;
  assign mem_req   = issue;
  assign mem_addr  = ptr;
  assign win_load  = load;
  assign win_wdata = take_nxt ? nxt_buf : fill_data;
endmodule

// File: rtl/hubwin_pc.sv
module hubwin_pc #(
  parameter int PC_W  = 9,
  parameter int IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PC_W-1:0] base,
  input  logic            branch,
  input  logic [PC_W-1:0] tgt,
  input  logic            step_ok,
  input  logic            stream_on,
  output logic [PC_W-1:0] pc
);
  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else if (start) pc <= base;
    else if (branch) pc <= tgt;
    else if (step_ok) begin
      if (stream_on) pc <= {pc[PC_W-1:IDX_W], pc[IDX_W-1:0] + IDX_W'(1)};
      else           pc <= pc + PC_W'(1);
    end
  end
endmodule

// File: rtl/hubwin_ctrl.sv
module hubwin_ctrl
  import hubwin_pkg::*;
#(
  parameter int PTR_W       = 18,
  parameter int WORD_W      = 32,
  parameter int WIN_WORDS   = 8,
  parameter int PC_W        = 9,
  parameter int SLOT_PERIOD = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [PTR_W-1:0]            start_ptr,
  input  logic [PC_W-1:0]             win_base,
  input  logic                        step,
  input  logic                        branch,
  input  logic [PC_W-1:0]             branch_tgt,
  output logic [PC_W-1:0]             pc,
  output logic                        stream_on,
  output logic                        stall,
  output logic                        mem_req,
  output logic [PTR_W-1:0]            mem_addr,
  input  logic                        fill_valid,
  input  logic [WORD_W*WIN_WORDS-1:0] fill_data,
  output logic                        win_we,
  output logic [PC_W-1:0]             win_waddr,
  output logic [WORD_W*WIN_WORDS-1:0] win_wdata
);
  localparam int LINE_W     = WORD_W * WIN_WORDS;
  localparam int LINE_BYTES = LINE_W / 8;
  localparam int IDX_W      = $clog2(WIN_WORDS);

  // Named internal events, visible to the bound checker.
  logic            slot_tick;
  logic            win_valid;
  logic            tgt_in_win;
  logic            br_leave;
  logic            step_ok;
  logic            wrap_evt;
  logic [PC_W-1:0] base_al;

  assign base_al    = {win_base[PC_W-1:IDX_W], {IDX_W{1'b0}}};
  assign tgt_in_win = same_window(32'(branch_tgt), 32'(base_al), IDX_W);
  assign br_leave   = branch & stream_on & ~tgt_in_win & ~start;
  assign stall      = stream_on & ~win_valid;
  assign step_ok    = step & ~stall;
  assign wrap_evt   = step_ok & stream_on & ~branch & ~start &
                      (pc[IDX_W-1:0] == IDX_W'(WIN_WORDS - 1));

  hubwin_slot #(.SLOT_PERIOD(SLOT_PERIOD)) u_slot (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (slot_tick)
  );

  hubwin_fetch #(
    .PTR_W     (PTR_W),
    .LINE_W    (LINE_W),
    .LINE_BYTES(LINE_BYTES)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .start_ptr (start_ptr),
    .slot_tick (slot_tick),
    .leave     (br_leave),
    .wrap      (wrap_evt),
    .fill_valid(fill_valid),
    .fill_data (fill_data),
    .stream_on (stream_on),
    .win_valid (win_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .win_load  (win_we),
    .win_wdata (win_wdata)
  );

  hubwin_pc #(.PC_W(PC_W), .IDX_W(IDX_W)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .base     (base_al),
    .branch   (branch),
    .tgt      (branch_tgt),
    .step_ok  (step_ok),
    .stream_on(stream_on),
    .pc       (pc)
  );

  assign win_waddr = base_al;
endmodule

// File: rtl/hubwin_ctrl_chk.sv
module hubwin_ctrl_chk #(
  parameter int PC_W       = 9,
  parameter int PTR_W      = 18,
  parameter int IDX_W      = 3,
  parameter int LINE_BYTES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             step,
  input logic             branch,
  input logic [PC_W-1:0]  branch_tgt,
  input logic             stall,
  input logic             stream_on,
  input logic [PC_W-1:0]  pc,
  input logic             mem_req,
  input logic [PTR_W-1:0] mem_addr,
  input logic             win_we,
  input logic             slot_tick,
  input logic             br_leave
);
  localparam logic [IDX_W-1:0] LAST = '1;

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_on && !stall && step && !branch && !start && pc[IDX_W-1:0] == LAST)
    |=> (pc[IDX_W-1:0] == '0) && (pc[PC_W-1:IDX_W] == $past(pc[PC_W-1:IDX_W])));

  p_addr_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> mem_addr == $past(mem_addr) + PTR_W'(LINE_BYTES));

  p_req_on_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> slot_tick);

  p_stall_streaming_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> stream_on);

  p_start_stalls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> stall && stream_on);

  p_local_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (branch && stream_on && !br_leave && !start) |=> stream_on && pc == $past(branch_tgt));

  p_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_leave |=> !stream_on && !stall);

  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_on |-> !win_we && !mem_req);

  p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && stream_on) |-> $past(win_we));
endmodule

bind hubwin_ctrl hubwin_ctrl_chk #(
  .PC_W      (PC_W),
  .PTR_W     (PTR_W),
  .IDX_W     (IDX_W),
  .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .step      (step),
  .branch    (branch),
  .branch_tgt(branch_tgt),
  .stall     (stall),
  .stream_on (stream_on),
  .pc        (pc),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .win_we    (win_we),
  .slot_tick (slot_tick),
  .br_leave  (br_leave)
);

// File: tb/hubwin_ctrl_test.sv
`timescale 1ns/100ps
module hubwin_ctrl_test;
  localparam int PTR_W = 18;
  localparam int PC_W  = 9;
  localparam int LW    = 256;
  localparam int SLOTS = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [PTR_W-1:0] start_ptr = '0;
  logic [PC_W-1:0]  win_base = '0;
  logic             step = 1'b0;
  logic             branch = 1'b0;
  logic [PC_W-1:0]  branch_tgt = '0;
  logic [PC_W-1:0]  pc;
  logic             stream_on, stall, mem_req, win_we;
  logic [PTR_W-1:0] mem_addr;
  logic             fill_valid = 1'b0;
  logic [LW-1:0]    fill_data = '0;
  logic [PC_W-1:0]  win_waddr;
  logic [LW-1:0]    win_wdata;

  hubwin_ctrl #(.SLOT_PERIOD(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .win_base(win_base), .step(step), .branch(branch), .branch_tgt(branch_tgt),
    .pc(pc), .stream_on(stream_on), .stall(stall), .mem_req(mem_req),
    .mem_addr(mem_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .win_we(win_we), .win_waddr(win_waddr), .win_wdata(win_wdata)
  );

  always #2.5 clk = ~clk;

  int nchk = 0, nfail = 0;
  int nreq = 0, nwe = 0;
  int lat = 3;
  int bc = 0;
  logic [PTR_W-1:0] exp_req = '0;
  logic [PTR_W-1:0] last_req = '0;
  logic [PC_W-1:0]  base_al = '0;
  logic [PTR_W-1:0] wq[$];

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] line_of(input logic [PTR_W-1:0] a);
    logic [LW-1:0] l;
    for (int i = 0; i < 8; i++) l[i*32 +: 32] = {a, 11'd0, 3'(i)};
    return l;
  endfunction

  // Slot phase counter from the requirement: slot at cycles 0, N, 2N ... after release.
  always @(posedge clk) begin
    if (!rst_n) bc <= 0;
    else bc <= (bc == SLOTS - 1) ? 0 : bc + 1;
  end

  // Memory model: one line per request, delivered lat+1 cycles later.
  int mcnt = 0;
  bit mbusy = 0;
  logic [PTR_W-1:0] maddr = '0;
  always @(negedge clk) begin
    #0.5;
    fill_valid = 1'b0;
    if (mbusy) begin
      if (mcnt == 0) begin
        fill_valid = 1'b1;
        fill_data  = line_of(maddr);
        mbusy      = 0;
      end else mcnt--;
    end
    if (mem_req && rst_n) begin
      mbusy = 1;
      mcnt  = lat;
      maddr = mem_addr;
    end
  end

  // Monitor: request addresses and window writes against the scoreboard.
  always @(negedge clk) begin
    #1.5;
    if (rst_n && mem_req) begin
      nreq++;
      last_req = mem_addr;
      chk(bc == 0, "R4 request in slot cycle", LW'(bc), 0);
      chk(mem_addr == exp_req, "R3 request address", LW'(mem_addr), LW'(exp_req));
      exp_req = exp_req + PTR_W'(32);
    end
    if (rst_n && win_we) begin
      nwe++;
      if (wq.size() == 0) chk(1'b0, "R1 unexpected window write", LW'(win_waddr), 0);
      else begin
        logic [PTR_W-1:0] a;
        a = wq.pop_front();
        chk(win_wdata == line_of(a), "R1 window data", win_wdata, line_of(a));
        chk(win_waddr == base_al, "R1 window address", LW'(win_waddr), LW'(base_al));
      end
    end
  end

  task automatic look();
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    look();
  endtask

  // Driver: issue a start and push the expected line sequence.
  task automatic start_stream(input logic [PTR_W-1:0] p, input logic [PC_W-1:0] b);
    @(negedge clk);
    start = 1'b1; start_ptr = p; win_base = b;
    base_al = {b[PC_W-1:3], 3'b000};
    exp_req = p;
    wq.delete();
    for (int k = 0; k < 16; k++) wq.push_back(p + PTR_W'(32 * k));
    @(negedge clk);
    start = 1'b0;
    look();
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200; i++) begin
      if (!stall) break;
      @(negedge clk);
      look();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look();
    chk(!stream_on && !stall && pc == 0 && !mem_req, "R5 reset state", {stream_on, stall, pc}, 0);

    // Start with an unaligned base: window at 0x048.
    lat = 3;
    w0 = nwe;
    start_stream(18'h01000, 9'h04D);
    chk(stream_on && stall, "R5 stall after start", {stream_on, stall}, 2'b11);
    chk(pc == 9'h048, "R5 pc at aligned base", LW'(pc), 9'h048);
    chk(nwe == w0, "R5 no write before first read", LW'(nwe), LW'(w0));
    wait_ready();
    chk(!stall && nwe == w0 + 1, "R5 window executable after first line", {stall, LW'(nwe)}, LW'(w0 + 1));

    // Background prefetch without command.
    idle(20);
    chk(nreq == 2, "R6 one background read", LW'(nreq), 2);

    // Step through the whole window; staged line replaces it on the wrap.
    lat = 30;
    w0 = nwe;
    @(negedge clk); step = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 7) step = 1'b0;
      look();
      chk(pc == base_al + PC_W'((i + 1) % 8), "R2 pc advance and wrap", LW'(pc), LW'(base_al + PC_W'((i + 1) % 8)));
    end
    chk(!stall && nwe == w0 + 1, "R6 staged line loaded on wrap", {stall, LW'(nwe)}, LW'(w0 + 1));

    // Local jump inside the window.
    w0 = nwe;
    @(negedge clk); branch = 1'b1; branch_tgt = base_al + 9'd5;
    @(negedge clk); branch = 1'b0;
    look();
    chk(pc == base_al + 9'd5 && stream_on, "R7 local jump", LW'(pc), LW'(base_al + 9'd5));
    chk(nwe == w0, "R7 no refill on local jump", LW'(nwe), LW'(w0));

    // Wrap before the slow line arrives.
    step = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      look();
    end
    chk(stall && pc == base_al, "R9 stall at wrap", {stall, pc}, {1'b1, base_al});
    repeat (5) @(negedge clk);
    look();
    chk(pc == base_al, "R9 steps ignored while stalled", LW'(pc), LW'(base_al));
    @(negedge clk); step = 1'b0;
    look();
    wait_ready();
    chk(!stall && nwe == w0 + 1 && pc == base_al, "R9 resume after line arrives", {stall, LW'(nwe)}, LW'(w0 + 1));

    // Branch out while a read is in flight.
    lat = 20;
    r0 = nreq;
    for (int i = 0; i < 50; i++) begin
      if (nreq != r0) break;
      @(negedge clk);
      look();
    end
    @(negedge clk); branch = 1'b1; branch_tgt = 9'h1F0; wq.delete();
    @(negedge clk); branch = 1'b0;
    look();
    chk(!stream_on && !stall && pc == 9'h1F0, "R8 branch out ends streaming", {stream_on, stall, pc}, 9'h1F0);
    w0 = nwe;
    r0 = nreq;
    step = 1'b1;
    repeat (10) @(negedge clk);
    step = 1'b0;
    look();
    chk(pc == 9'h1FA, "R8 full pc increments", LW'(pc), 9'h1FA);
    idle(30);
    chk(nwe == w0, "R8 in-flight line discarded", LW'(nwe), LW'(w0));
    chk(nreq == r0, "R8 no reads after branch out", LW'(nreq), LW'(r0));

    // Pointer wrap at the top of the 18-bit space.
    lat = 2;
    r0 = nreq;
    start_stream(18'h3FFE0, 9'h100);
    chk(stall && pc == 9'h100, "R5 restart stalls at new base", {stall, pc}, {1'b1, 9'h100});
    wait_ready();
    idle(20);
    chk(nreq == r0 + 2 && last_req == '0, "R3 pointer rolls over to zero", LW'(last_req), 0);

    idle(2);
    finish_run();
  end
endmodule